// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a synchronous serial slave that gives an external master read and write access to a bank of 64 sixteen-bit registers. The master selects the slave with an active-low select line, supplies a serial clock and exchanges bits on one data line. The data line is split at this boundary into an input, an output and an output enable, and the pad joins them. All serial inputs pass through synchronizers and are sampled by the system clock, so the serial clock must run several times slower than the system clock.

Every transfer opens with a 16-bit command word. Its top bit picks read (1) or write (0). A four-bit tag field follows, then a bit that selects the snapshot bank, then a six-bit start address, and last a four-bit word count. Data words then move to or from consecutive addresses. After the counted words the slave returns a safety word that carries a checksum over the whole transfer. A count of zero turns the transfer into an endless readout of one register. A select pulse that has no clock edges in it freezes a copy of the lowest registers into a snapshot bank, and a read can then return those frozen values.

Top module: `ssc_reg_slave`

## Requirements
- R1: Words travel most significant bit first. The slave changes its output bit only after a rising serial-clock edge or at the end of a word, and it samples input bits on falling edges.
- R2: Command word fields: bit 15 is read(1)/write(0), bits 14..11 are the tag, bit 10 is snapshot-select, bits 9..4 are the start address and bits 3..0 are the word count N. A write with N ≥ 1 stores N received words at consecutive addresses.
- R3: The address increments after each data word and wraps from 0x3F to 0x00.
- R4: A read with N ≥ 1 returns N words from consecutive addresses. The first word is ready for the first data bit after a fixed turnaround gap of one serial-clock period.
- R5: With N = 0, a read returns the same address on every word and never appends a safety word, until the select line goes high.
- R6: After the N-th data word (N ≥ 1), the slave sends a safety word. Its upper byte is {1, 0, 0, 0, tag[3:0]} and its lower byte is the bitwise inverse of a CRC-8 with polynomial 0x1D and start value 0xFF, taken over every bit of the command and data words, MSB first.
- R7: After the safety word the slave releases the data line and ignores further clocks until the select line goes high. Words clocked in during that time are not written.
- R8: Select going high at any point aborts the transfer. A partly received word is not written, and the next transfer starts with a fresh checksum.
- R9: A select pulse with no serial-clock edges copies live registers 0..NSNAP-1 into the snapshot bank. A read with snapshot-select = 1 returns the snapshot copy for those addresses and the live values elsewhere. Pulses that contain clock edges leave the snapshot unchanged.
- R10: The output enable is low during the command word, during write data and while deselected. It is high during read data and the safety word.
- R11: After reset all registers read 0 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low slave select from the master |
| sclk | input | 1 | Serial clock from the master, idle low |
| sdi | input | 1 | Data line, input side |
| sdo | output | 1 | Data line, output side (0 when not driving) |
| sdo_oe | output | 1 | Enable for the data line driver |

## Verification
The bench builds the block with its defaults, NSNAP = 4 and SYNC = 2, and runs the serial clock at sixteen system clocks per bit. With a four-entry snapshot bank, one snapshot read can cross from frozen addresses into live ones (2, 3, 4). The full 64-entry array lets a write and a read run across the 0x3F to 0x00 wrap. The shallow synchronizer leaves enough margin inside each half serial period to check every output bit at the master's falling-edge sample point.

// File: rtl/ssc_reg_slave.sv
module ssc_reg_slave #(
  parameter int NSNAP = 4,
  parameter int SYNC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int DEPTH = 64;
  localparam int SW    = $clog2(NSNAP);

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_SAFE, PH_DONE} phase_t;

  logic [SYNC:0]   cs_p, ck_p;
  logic [SYNC-1:0] di_p;
  logic [15:0] mem  [DEPTH];
  logic [15:0] snap [NSNAP];
  phase_t      ph;
  logic [3:0]  cnt, len, left, lock;
  logic [5:0]  addr;
  logic [15:0] sh;
  logic [7:0]  crc;
  logic        rw, upd, pend, seen;

  logic        cs_s, di_s, rise_e, fall_e, cs_rise, snap_evt, tx_on;
  logic        cmd_done, word_end, bit_in, upd_nx;
  logic [15:0] word_in, rd_data;
  logic [7:0]  crc_nx;
  logic [5:0]  addr_nx;

  assign cs_s     = cs_p[SYNC-1];
  assign di_s     = di_p[SYNC-1];
  assign rise_e   = ck_p[SYNC-1] & ~ck_p[SYNC];
  assign fall_e   = ~ck_p[SYNC-1] & ck_p[SYNC];
  assign cs_rise  = cs_s & ~cs_p[SYNC];
  assign snap_evt = cs_rise & ~seen;

  assign tx_on  = (ph == PH_DATA && rw) || ph == PH_SAFE;
  assign sdo_oe = ~cs_s & tx_on;
  assign sdo    = sdo_oe & sh[15];

  assign word_in = {sh[14:0], di_s};
  assign bit_in  = tx_on ? sh[15] : di_s;
  assign crc_nx  = {crc[6:0], 1'b0} ^ ((crc[7] ^ bit_in) ? 8'h1D : 8'h00);

  assign cmd_done = fall_e && ph == PH_CMD  && cnt == 4'd15;
  assign word_end = fall_e && ph == PH_DATA && cnt == 4'd15;
  assign addr_nx  = cmd_done ? word_in[9:4] : (len == 4'd0 ? addr : addr + 6'd1);
  assign upd_nx   = cmd_done ? word_in[10] : upd;
  assign rd_data  = (upd_nx && int'(addr_nx) < NSNAP) ? snap[addr_nx[SW-1:0]] : mem[addr_nx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
      ph   <= PH_CMD;
      cnt  <= '0;
      len  <= '0;
      left <= '0;
      lock <= '0;
      addr <= '0;
      sh   <= '0;
      crc  <= 8'hFF;
      rw   <= 1'b0;
      upd  <= 1'b0;
      pend <= 1'b0;
      seen <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < NSNAP; i++) snap[i] <= '0;
    end else begin
      cs_p <= {cs_p[SYNC-1:0], cs_n};
      ck_p <= {ck_p[SYNC-1:0], sclk};
      di_p <= {di_p[SYNC-2:0], sdi};
      if (snap_evt)
        for (int i = 0; i < NSNAP; i++) snap[i] <= mem[i];
      if (cs_s) begin
        ph   <= PH_CMD;
        cnt  <= '0;
        crc  <= 8'hFF;
        pend <= 1'b0;
        seen <= 1'b0;
      end else begin
        if (rise_e || fall_e) seen <= 1'b1;
        if (rise_e && pend) begin
          sh   <= {sh[14:0], 1'b0};
          pend <= 1'b0;
        end
        if (fall_e && ph != PH_DONE) begin
          crc <= crc_nx;
          cnt <= cnt + 4'd1;
          if (!tx_on) sh <= word_in;
          else if (cnt != 4'd15) pend <= 1'b1;
          if (cmd_done) begin
            rw   <= word_in[15];
            lock <= word_in[14:11];
            upd  <= word_in[10];
            addr <= word_in[9:4];
            len  <= word_in[3:0];
            left <= word_in[3:0];
            ph   <= PH_DATA;
            if (word_in[15]) sh <= rd_data;
          end
          if (word_end) begin
            if (!rw) mem[addr] <= word_in;
            addr <= addr_nx;
            left <= left - 4'd1;
            if (len != 4'd0 && left == 4'd1) begin
              ph <= PH_SAFE;
              sh <= {1'b1, 3'b000, lock, ~crc_nx};
            end else if (rw) begin
              sh <= rd_data;
            end
          end
          if (ph == PH_SAFE && cnt == 4'd15) ph <= PH_DONE;
        end
      end
    end
  end
endmodule

module ssc_reg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_s,
  input logic        rise_e,
  input logic        fall_e,
  input logic [1:0]  ph,
  input logic [3:0]  len,
  input logic [5:0]  addr,
  input logic [7:0]  crc,
  input logic        word_end,
  input logic        snap_evt,
  input logic [15:0] snap0,
  input logic [15:0] mem0,
  input logic        sdo,
  input logic        sdo_oe
);
  localparam logic [1:0] CMD = 2'd0, DATA = 2'd1, SAFE = 2'd2;

  p_sdo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_e && !fall_e && !cs_s) |=> (cs_s || $stable(sdo)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && len != 4'd0 && addr == 6'h3F) |=> addr == 6'h00);

  p_no_trailer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == DATA && len == 4'd0 && !cs_s) |=> ph != SAFE);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (ph == CMD && crc == 8'hFF));

  p_snap_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> snap0 == $past(mem0));

  p_oe_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ph == CMD |-> !sdo_oe);
endmodule

bind ssc_reg_slave ssc_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise_e(rise_e), .fall_e(fall_e),
  .ph(ph), .len(len), .addr(addr), .crc(crc), .word_end(word_end),
  .snap_evt(snap_evt), .snap0(snap[0]), .mem0(mem[0]), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tb_ssc_reg_slave.sv
`timescale 1ns/1ps
module tb_ssc_reg_slave;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe;
  always #2 clk = ~clk;

  ssc_reg_slave #(.NSNAP(NS), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] mm [64];
  logic [15:0] ms [NS];
  logic [15:0] wbuf [4];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] got_w;
  event        got_ev;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always begin
    @(got_ev);
    if (exp_q.size() == 0) chk(0, "scoreboard underflow", got_w, 16'h0);
    else begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got_w === e, t, got_w, e);
    end
  end

  function automatic logic [7:0] crc_w(input logic [7:0] c0, input logic [15:0] w);
    logic [7:0] c;
    c = c0;
    for (int i = 15; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ w[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return c;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xword(input logic [15:0] tx, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      sdi = tx[i];
      sclk = 1;
      wclk(8);
      rx[i] = sdo;
      sclk = 0;
      wclk(8);
    end
  endtask

  task automatic end_x();
    wclk(4);
    cs_n = 1;
    wclk(12);
  endtask

  task automatic write_x(input logic [3:0] lk, input logic [5:0] a, input int n, input bit extra);
    logic [15:0] cmd, rx;
    logic [7:0]  c;
    logic [5:0]  aa;
    cmd = {1'b0, lk, 1'b0, a, 4'(n)};
    c = crc_w(8'hFF, cmd);
    aa = a;
    cs_n = 0;
    wclk(8);
    xword(cmd, rx);
    chk(sdo_oe === 1'b0, "R10 oe low after write command", {15'b0, sdo_oe}, 16'h0);
    for (int i = 0; i < n; i++) begin
      xword(wbuf[i], rx);
      c = crc_w(c, wbuf[i]);
      mm[aa] = wbuf[i];
      aa++;
    end
    wclk(16);
    exp_q.push_back({1'b1, 3'b000, lk, ~c});
    tag_q.push_back("R6 write safety word");
    xword(16'h0, rx);
    got_w = rx;
    ->got_ev;
    if (extra) begin
      wclk(4);
      chk(sdo_oe === 1'b0, "R7 line released after safety", {15'b0, sdo_oe}, 16'h0);
      xword(16'hFFFF, rx);
    end
    end_x();
  endtask

  task automatic read_x(input logic [3:0] lk, input bit up, input logic [5:0] a, input int n,
                        input int reps, input string tag);
    logic [15:0] cmd, rx, e;
    logic [7:0]  c;
    logic [5:0]  aa;
    int k;
    cmd = {1'b1, lk, up, a, 4'(n)};
    c = crc_w(8'hFF, cmd);
    aa = a;
    k = (n == 0) ? reps : n;
    cs_n = 0;
    wclk(8);
    xword(cmd, rx);
    wclk(16);
    chk(sdo_oe === 1'b1, "R10 oe high for read data", {15'b0, sdo_oe}, 16'h1);
    for (int i = 0; i < k; i++) begin
      e = (up && int'(aa) < NS) ? ms[aa] : mm[aa];
      exp_q.push_back(e);
      tag_q.push_back(tag);
      xword(16'h0, rx);
      c = crc_w(c, e);
      got_w = rx;
      ->got_ev;
      if (n != 0) aa++;
    end
    if (n != 0) begin
      exp_q.push_back({1'b1, 3'b000, lk, ~c});
      tag_q.push_back("R6 read safety word");
      xword(16'h0, rx);
      got_w = rx;
      ->got_ev;
    end else begin
      chk(sdo_oe === 1'b1, "R5 still sending data, no trailer", {15'b0, sdo_oe}, 16'h1);
    end
    end_x();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mm[i] = '0;
    for (int i = 0; i < NS; i++) ms[i] = '0;
    wclk(5);
    rst_n = 1;
    wclk(5);
    chk(sdo_oe === 1'b0, "R11 oe low after reset", {15'b0, sdo_oe}, 16'h0);
    read_x(4'h0, 0, 6'h00, 2, 0, "R11 reset contents");

    wbuf[0] = 16'h1234; wbuf[1] = 16'h8001; wbuf[2] = 16'hBEEF; wbuf[3] = 16'h0F0F;
    write_x(4'h5, 6'h00, 4, 0);
    read_x(4'hA, 0, 6'h00, 4, 0, "R4 R2 R1 consecutive read of written data");

    wbuf[0] = 16'hA1A1; wbuf[1] = 16'hB2B2; wbuf[2] = 16'hC3C3;
    write_x(4'h3, 6'h3E, 3, 0);
    read_x(4'h0, 0, 6'h3F, 2, 0, "R3 read across address wrap");

    read_x(4'h7, 0, 6'h02, 0, 3, "R5 repeated readout of one address");

    cs_n = 0;
    wclk(8);
    begin
      logic [15:0] rx;
      xword({1'b0, 4'h0, 1'b0, 6'h05, 4'd1}, rx);
    end
    for (int i = 0; i < 8; i++) begin
      sdi = 1; sclk = 1; wclk(8); sclk = 0; wclk(8);
    end
    cs_n = 1;
    wclk(12);
    chk(sdo_oe === 1'b0, "R8 oe low after abort", {15'b0, sdo_oe}, 16'h0);
    read_x(4'h0, 0, 6'h05, 1, 0, "R8 aborted word not written");
    wbuf[0] = 16'h6666;
    write_x(4'h9, 6'h06, 1, 0);

    wbuf[0] = 16'h7777;
    write_x(4'h2, 6'h10, 1, 1);
    read_x(4'h0, 0, 6'h10, 2, 0, "R7 clocks after safety ignored");

    cs_n = 0;
    wclk(8);
    cs_n = 1;
    wclk(12);
    for (int i = 0; i < NS; i++) ms[i] = mm[i];
    wbuf[0] = 16'h5555;
    write_x(4'h1, 6'h00, 1, 0);
    read_x(4'h0, 1, 6'h02, 3, 0, "R9 snapshot read across bank edge");
    read_x(4'h0, 1, 6'h00, 1, 0, "R9 snapshot keeps frozen value");
    read_x(4'h0, 0, 6'h00, 1, 0, "R9 live value after snapshot");

    wclk(4);
    chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule